// File: doc/BRIEF.md
# Charge Pump Mode Selection Controller

This block decides which multiplication ratio a switched-capacitor LED supply runs at: unity (1x), one-and-a-half (1.5x) or double (2x). It watches a low-headroom comparator flag on each of six LED current sinks. The sinks are grouped in three banks of two, and each bank has its own enable. A sink counts as active only when its bank is enabled and its short-to-rail flag is clear. When any active sink reports low headroom for a fixed, parameterised number of consecutive clock cycles, the controller moves to the next ratio. From 2x the next step wraps to 1x, so headroom that stays low makes the ratio cycle.

The controller never steps down by itself. It returns to 1x only when the register block sends a one-cycle restart strobe. An undervoltage or overtemperature flag sends it into shutdown. It stays in shutdown until the enable input is taken low and then high again.

The state machine has five named states: OFF (disabled), ONE_X, ONE_HALF_X, TWO_X and SHUTDOWN. Its transitions, in priority order, are:
- disable: any state goes to OFF.
- fault: any state goes to SHUTDOWN.
- hold: SHUTDOWN stays in SHUTDOWN.
- wake: OFF goes to ONE_X.
- restart: any running state goes to ONE_X.
- step: ONE_X goes to ONE_HALF_X, ONE_HALF_X goes to TWO_X, and TWO_X goes to ONE_X.

Top module: `cp_mode_ctrl`

## Requirements
- R1: While `enable` is low, `pump_mode` is 2'b00 and `shutdown` is 0 from the next cycle on. After reset the same values hold.
- R2: `pump_mode` encodes 1x as 2'b00, 1.5x as 2'b01 and 2x as 2'b10, and never shows 2'b11. The OFF and SHUTDOWN states both output 2'b00.
- R3: A step is taken when `hdrm_low` has been high on at least one active channel at FILTER_CYCLES consecutive rising edges. The new mode appears right after the FILTER_CYCLES-th such edge. Shorter runs cause no step.
- R4: Steps go 1x to 1.5x to 2x, and from 2x back to 1x. Low headroom that persists therefore cycles through the three modes.
- R5: A flag on channel i is ignored when bit i/2 of `bank_on` is 0. Channels 0 and 1 belong to bank bit 0.
- R6: A flag on channel i is ignored while `short_det[i]` is 1. The channel is monitored again once `short_det[i]` clears.
- R7: The persistence count restarts when no active channel is low for one cycle, and after every step. Each further step needs a fresh full run.
- R8: A `restart` strobe while running gives 1x in the next cycle, and the persistence count starts from zero.
- R9: `uv_fault` or `ot_fault` while `enable` is high gives `shutdown`=1 and `pump_mode`=2'b00 in the next cycle.
- R10: Shutdown persists after the fault clears, and ignores `restart` and headroom flags, until `enable` goes low. The next enable restarts at 1x with normal selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Device enable |
| bank_on | input | 3 | Per-bank enable, bit b covers channels 2b and 2b+1 |
| hdrm_low | input | 6 | Per-channel low-headroom comparator flags |
| short_det | input | 6 | Per-channel short-to-rail flags |
| restart | input | 1 | One-cycle strobe: return to 1x |
| uv_fault | input | 1 | Supply undervoltage |
| ot_fault | input | 1 | Die overtemperature |
| pump_mode | output | 2 | Selected ratio code |
| shutdown | output | 1 | Shutdown indication |

## Verification
Every result is registered once. A change applied to the inputs before a rising edge shows on `pump_mode` and `shutdown` right after that edge. The one exception is a headroom step, which appears after the FILTER_CYCLES-th consecutive qualifying edge.

The bench drives inputs at the falling edge and advances its reference model at the rising edge. It compares the outputs at the following falling edge, so each check lands exactly one edge after its stimulus. The directed phases also probe the edge just before each step (FILTER_CYCLES-1 edges) and the edge on which it lands, which pins down the filter length.

// File: rtl/cp_mode_pkg.sv
package cp_mode_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_ONE_X,
        ST_ONE_HALF_X,
        ST_TWO_X,
        ST_SHUTDOWN
    } pump_state_e;

    localparam logic [1:0] CODE_1X  = 2'b00;
    localparam logic [1:0] CODE_15X = 2'b01;
    localparam logic [1:0] CODE_2X  = 2'b10;

    function automatic pump_state_e next_ratio(input pump_state_e cur);
        pump_state_e nxt;
        unique case (cur)
            ST_ONE_X:      nxt = ST_ONE_HALF_X;
            ST_ONE_HALF_X: nxt = ST_TWO_X;
            ST_TWO_X:      nxt = ST_ONE_X;
            default:       nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/cp_hdrm_qual.sv
module cp_hdrm_qual #(
    parameter int NUM_BANKS   = 3,
    parameter int CH_PER_BANK = 2,
    localparam int NUM_CH     = NUM_BANKS * CH_PER_BANK
) (
    input  logic [NUM_BANKS-1:0] bank_on,
    input  logic [NUM_CH-1:0]    hdrm_low,
    input  logic [NUM_CH-1:0]    short_det,
    output logic                 any_low
);

    logic [NUM_CH-1:0] watched;

    // Channel ch is watched when its bank is on and no short is flagged on it.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        assign watched[ch] = bank_on[ch / CH_PER_BANK] & ~short_det[ch];
    end

    assign any_low = |(hdrm_low & watched);

endmodule

// File: rtl/cp_persist_filter.sv
module cp_persist_filter #(
    parameter int FILTER_CYCLES = 800,
    localparam int CW = $clog2(FILTER_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic any_low,
    input  logic restart,
    output logic step
);

    logic [CW-1:0] cnt;
    logic          clr;

    assign step = run & any_low & (cnt == CW'(FILTER_CYCLES - 1));
    assign clr  = ~run | ~any_low | restart | step;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(FILTER_CYCLES));

    // R7
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_low || step) |=> cnt == '0);

endmodule

// File: rtl/cp_mode_fsm.sv
module cp_mode_fsm
    import cp_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       fault,
    input  logic       restart,
    input  logic       step,
    output logic       run,
    output logic [1:0] pump_mode,
    output logic       shutdown
);

    pump_state_e cur, nxt;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur <= ST_OFF;
        else        cur <= nxt;
    end

    // Transitions, in priority order: disable, fault, hold, wake, restart, step.
    always_comb begin
        nxt = cur;
        if (!enable) begin
            nxt = ST_OFF;
        end else if (fault) begin
            nxt = ST_SHUTDOWN;
        end else begin
            unique case (cur)
                ST_OFF:      nxt = ST_ONE_X;
                ST_SHUTDOWN: nxt = ST_SHUTDOWN;
                ST_ONE_X, ST_ONE_HALF_X, ST_TWO_X: begin
                    if (restart)   nxt = ST_ONE_X;
                    else if (step) nxt = next_ratio(cur);
                end
                default:     nxt = ST_OFF;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        run       = 1'b0;
        shutdown  = 1'b0;
        pump_mode = CODE_1X;
        unique case (cur)
            ST_OFF:        ;
            ST_ONE_X:      run = 1'b1;
            ST_ONE_HALF_X: begin run = 1'b1; pump_mode = CODE_15X; end
            ST_TWO_X:      begin run = 1'b1; pump_mode = CODE_2X;  end
            ST_SHUTDOWN:   shutdown = 1'b1;
            default:       ;
        endcase
    end

    // R1
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (pump_mode == CODE_1X) && !shutdown);

    // R2
    code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pump_mode != 2'b11);

    // R4
    step_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !fault && !restart && step && cur == ST_TWO_X) |=> cur == ST_ONE_X);

    // R8
    restart_one_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !fault && restart && run) |=> pump_mode == CODE_1X && run);

    // R9
    fault_shut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && fault) |=> shutdown && pump_mode == CODE_1X);

    // R10
    shut_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shutdown && enable) |=> shutdown);

endmodule

// File: rtl/cp_mode_ctrl.sv
module cp_mode_ctrl #(
    parameter int NUM_BANKS     = 3,
    parameter int CH_PER_BANK   = 2,
    parameter int FILTER_CYCLES = 800,
    localparam int NUM_CH       = NUM_BANKS * CH_PER_BANK
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic [NUM_BANKS-1:0] bank_on,
    input  logic [NUM_CH-1:0]    hdrm_low,
    input  logic [NUM_CH-1:0]    short_det,
    input  logic                 restart,
    input  logic                 uv_fault,
    input  logic                 ot_fault,
    output logic [1:0]           pump_mode,
    output logic                 shutdown
);

    logic any_low, run, step;

    cp_hdrm_qual #(
        .NUM_BANKS  (NUM_BANKS),
        .CH_PER_BANK(CH_PER_BANK)
    ) u_qual (
        .bank_on  (bank_on),
        .hdrm_low (hdrm_low),
        .short_det(short_det),
        .any_low  (any_low)
    );

    cp_persist_filter #(
        .FILTER_CYCLES(FILTER_CYCLES)
    ) u_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .any_low(any_low),
        .restart(restart),
        .step   (step)
    );

    cp_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .fault    (uv_fault | ot_fault),
        .restart  (restart),
        .step     (step),
        .run      (run),
        .pump_mode(pump_mode),
        .shutdown (shutdown)
    );

endmodule

// File: tb/test_cp_mode_ctrl.sv
module test_cp_mode_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int F = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [2:0] bank_on = 3'b111;
    logic [5:0] hdrm_low = '0;
    logic [5:0] short_det = '0;
    logic       restart = 1'b0;
    logic       uv_fault = 1'b0;
    logic       ot_fault = 1'b0;
    logic [1:0] pump_mode;
    logic       shutdown;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // Reference model: 0 off, 1 one-x, 2 one-half-x, 3 two-x, 4 shutdown.
    int m_st = 0;
    int m_cnt = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cp_mode_ctrl #(.FILTER_CYCLES(F)) i_cp_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .enable(enable), .bank_on(bank_on),
        .hdrm_low(hdrm_low), .short_det(short_det), .restart(restart),
        .uv_fault(uv_fault), .ot_fault(ot_fault),
        .pump_mode(pump_mode), .shutdown(shutdown));

    function automatic logic [1:0] exp_code(int st);
        case (st)
            2: return 2'b01;
            3: return 2'b10;
            default: return 2'b00;
        endcase
    endfunction

    function automatic bit exp_low(logic [2:0] banks, logic [5:0] lows, logic [5:0] shorts);
        bit r = 0;
        for (int c = 0; c < 6; c++)
            if (banks[c / 2] && !shorts[c] && lows[c]) r = 1;
        return r;
    endfunction

    task automatic model_step();
        if (!rst_n) begin
            m_st = 0; m_cnt = 0;
        end else if (!enable) begin
            m_st = 0; m_cnt = 0;
        end else if (uv_fault || ot_fault) begin
            m_st = 4; m_cnt = 0;
        end else if (m_st == 4) begin
            m_cnt = 0;
        end else if (m_st == 0) begin
            m_st = 1; m_cnt = 0;
        end else if (restart) begin
            m_st = 1; m_cnt = 0;
        end else if (exp_low(bank_on, hdrm_low, short_det)) begin
            if (m_cnt == F - 1) begin
                m_st = (m_st == 3) ? 1 : m_st + 1;
                m_cnt = 0;
            end else begin
                m_cnt++;
            end
        end else begin
            m_cnt = 0;
        end
    endtask

    task automatic chk(string tag, int act, int expv, string what);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, expv);
        end
    endtask

    // One clock: model advances at the rising edge, outputs compared at the falling edge.
    task automatic tick(string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk(tag, pump_mode, exp_code(m_st), "pump_mode");
        chk(tag, shutdown, (m_st == 4) ? 1 : 0, "shutdown");
        chk("R2", (pump_mode == 2'b11) ? 1 : 0, 0, "illegal code");
    endtask

    task automatic ticks(int n, string tag);
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h1a2b3c4d));
        @(negedge clk);
        // R1: reset state
        chk("R1", pump_mode, 0, "reset mode");
        chk("R1", shutdown, 0, "reset shutdown");
        rst_n = 1'b1;
        ticks(2, "R1");
        enable = 1'b1;
        ticks(3, "R1");

        // R3: step lands exactly on the F-th edge
        hdrm_low = 6'b000001;
        ticks(F - 1, "R3");
        chk("R3", pump_mode, 2'b00, "before step");
        tick("R3");
        chk("R3", pump_mode, 2'b01, "after step");

        // R7, R4: each further step needs a full run; 2x wraps to 1x
        ticks(F - 1, "R7");
        chk("R7", pump_mode, 2'b01, "no early second step");
        tick("R4");
        chk("R4", pump_mode, 2'b10, "1.5x to 2x");
        ticks(F, "R4");
        chk("R4", pump_mode, 2'b00, "2x wraps to 1x");
        ticks(F, "R4");
        chk("R4", pump_mode, 2'b01, "cycle resumes");

        // R7: one quiet cycle restarts the count
        ticks(F - 1, "R7");
        hdrm_low = '0;
        tick("R7");
        hdrm_low = 6'b100000;
        ticks(F - 1, "R7");
        chk("R7", pump_mode, 2'b01, "count restarted");

        // R8: restart returns to 1x and the count starts over
        restart = 1'b1;
        tick("R8");
        restart = 1'b0;
        chk("R8", pump_mode, 2'b00, "restart");
        ticks(F - 1, "R8");
        chk("R8", pump_mode, 2'b00, "fresh count");
        hdrm_low = '0;
        tick("R8");

        // R5: a disabled bank is ignored
        bank_on = 3'b110;
        hdrm_low = 6'b000011;
        ticks(2 * F, "R5");
        chk("R5", pump_mode, 2'b00, "disabled bank");

        // R6: a shorted channel is ignored, then returns
        bank_on = 3'b111;
        hdrm_low = 6'b000100;
        short_det = 6'b000100;
        ticks(2 * F, "R6");
        chk("R6", pump_mode, 2'b00, "shorted channel");
        short_det = '0;
        ticks(F, "R6");
        chk("R6", pump_mode, 2'b01, "channel back");
        hdrm_low = '0;

        // R9, R10: fault latches shutdown until re-enable
        uv_fault = 1'b1;
        tick("R9");
        uv_fault = 1'b0;
        chk("R9", shutdown, 1, "uv shutdown");
        chk("R9", pump_mode, 2'b00, "uv mode");
        restart = 1'b1;
        hdrm_low = 6'b111111;
        tick("R10");
        restart = 1'b0;
        ticks(2 * F, "R10");
        chk("R10", shutdown, 1, "sticky");
        chk("R10", pump_mode, 2'b00, "sticky mode");
        enable = 1'b0;
        tick("R1");
        chk("R1", shutdown, 0, "disabled");
        enable = 1'b1;
        ticks(F + 1, "R10");
        chk("R10", pump_mode, 2'b01, "resumes after re-enable");
        ot_fault = 1'b1;
        tick("R9");
        ot_fault = 1'b0;
        chk("R9", shutdown, 1, "ot shutdown");
        enable = 1'b0;
        hdrm_low = '0;
        tick("R1");
        enable = 1'b1;

        // Random segments checked against the model on every edge.
        for (int seg = 0; seg < 400; seg++) begin
            int len;
            len = 1 + int'($urandom_range(2 * F + 4));
            hdrm_low  = ($urandom_range(3) == 0) ? 6'b0 : 6'($urandom);
            bank_on   = ($urandom_range(3) == 0) ? 3'($urandom) : 3'b111;
            short_det = ($urandom_range(4) == 0) ? 6'($urandom) : 6'b0;
            for (int k = 0; k < len; k++) begin
                restart  = ($urandom_range(39) == 0);
                uv_fault = ($urandom_range(299) == 0);
                ot_fault = ($urandom_range(299) == 0);
                if ($urandom_range(149) == 0) enable = ~enable;
                else if (!enable && $urandom_range(3) == 0) enable = 1'b1;
                tick("R4");
            end
        end
        finish_run();
    end

endmodule